// File: doc/BRIEF.md
# Multiplexed-Bus Memory Target

This block is a synchronous target on a 32-bit PCI-style bus where address and data share one set of lines. It watches for the start of a transaction and decodes the command and address that arrive in the first cycle. When the command is a memory read or memory write aimed at its 16-word (64-byte) register window, it claims the transaction by pulling its select output low. It then moves one word per completed data phase, either into its register file under per-byte enables or out onto the shared lines.

All control lines are active low, and every input is sampled on the rising clock edge. The initiator keeps its request line low while more data phases follow and raises it for the last one. A word moves only on an edge where both the initiator-ready and target-ready lines are low. During a burst the word address advances by one word (4 bytes) per completed phase and wraps inside the window. Reads drive the bus one cycle after the address phase, and target-ready is asserted in that same cycle.

Top module: `mux_bus_target`

## Requirements
- R1: After reset, claim_n and tgt_rdy_n are 1, ad_oe is 0, and every register reads as zero.
- R2: An address phase (first cycle with txn_req_n low after a cycle with it high) claims the access when cmd_be_n is 4'b0110 (memory read) or 4'b0111 (memory write), ad_i[31:6] equals BASE_ADDR[31:6] and ad_i[1:0] is 2'b00. In that case claim_n and tgt_rdy_n are 0 in the next cycle.
- R3: Any other command, or an address outside the window, leaves claim_n high for the whole transaction and changes no register.
- R4: On a completed write phase, byte lane i (ad_i bits 8i+7..8i) of the addressed word is updated only when cmd_be_n[i] is 0. Other lanes keep their value.
- R5: For a claimed read, ad_oe is 1 from the cycle after the address phase, and ad_o carries the word at index ad_i[5:2] of the address phase.
- R6: A data phase completes only on an edge where init_rdy_n is 0. While init_rdy_n is 1, nothing is written, the word address holds and the claim stays.
- R7: Each completed phase that is not the last advances the word index by one, modulo 16, so a burst wraps within the window.
- R8: The phase that completes with txn_req_n high is the last. In the next cycle claim_n and tgt_rdy_n are 1 and ad_oe is 0.
- R9: Data phases of a transaction that was not claimed are never decoded as an address phase, even when they carry a valid command and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_req_n | input | 1 | Transaction request from initiator, low while phases remain |
| ad_i | input | 32 | Shared address/data lines as seen by the target |
| ad_o | output | 32 | Read data driven onto the shared lines |
| ad_oe | output | 1 | High while the target drives ad_o |
| cmd_be_n | input | 4 | Command in address phase, active-low byte enables in data phases |
| init_rdy_n | input | 1 | Initiator ready, active low |
| tgt_rdy_n | output | 1 | Target ready, active low |
| claim_n | output | 1 | Device-select response, active low |

## Verification
The hardest situation to reach from the ports is a transaction for some other agent whose data phases happen to look like a valid address phase. A target that decodes naively would claim mid-transfer. The stimulus starts an unclaimed I/O-style transaction and fills each of its data phases with the window base address and the memory-write code, then reads the window back. Wait states inside both read and write bursts, burst wrap past the last word, and a sweep of all sixteen byte-enable patterns and all sixteen command codes cover the other corners.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2
    } tgt_st_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    localparam int LANE_W = 8;

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
    import mbt_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          IDX_W     = 4,
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    output logic              hit,
    output logic              is_wr,
    output logic [IDX_W-1:0]  idx
);
    localparam int OFF_W = IDX_W + 2;

    logic cmd_ok;
    logic in_win;

    always_comb begin
        cmd_ok = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
        in_win = (addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]) &&
                 (addr[1:0] == 2'b00);
        hit    = cmd_ok && in_win;
        is_wr  = (cmd == CMD_MEM_WR);
        idx    = addr[OFF_W-1:2];
    end

endmodule

// File: rtl/mbt_regs.sv
module mbt_regs
    import mbt_pkg::*;
#(
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W/LANE_W-1:0]   be_n,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [DATA_W-1:0]          rdata
);
    localparam int LANES = DATA_W / LANE_W;

    logic [WORDS-1:0][DATA_W-1:0] mem_d, mem_q;
    logic [LANES-1:0]             lane_en;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_en[b] = we & ~be_n[b];

        AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (we && be_n[b]) |=> mem_q[$past(wr_idx)][b*LANE_W +: LANE_W] ==
                                $past(mem_q[wr_idx][b*LANE_W +: LANE_W])); // R4
    end

    always_comb begin
        mem_d = mem_q;
        for (int b = 0; b < LANES; b++) begin
            if (lane_en[b]) begin
                mem_d[wr_idx][b*LANE_W +: LANE_W] = wdata[b*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[rd_idx];

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q)); // R3

endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target
    import mbt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
    parameter int          WIN_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        txn_req_n,
    input  logic [31:0] ad_i,
    output logic [31:0] ad_o,
    output logic        ad_oe,
    input  logic [3:0]  cmd_be_n,
    input  logic        init_rdy_n,
    output logic        tgt_rdy_n,
    output logic        claim_n
);
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(WIN_WORDS);

    typedef struct packed {
        tgt_st_e          st;
        logic [IDX_W-1:0] idx;
        logic             req_prev;
    } tgt_regs_t;

    localparam tgt_regs_t REGS_RST = '{st: ST_IDLE, idx: '0, req_prev: 1'b1};

    tgt_regs_t r_d, r_q;

    logic             dec_hit;
    logic             dec_wr;
    logic [IDX_W-1:0] dec_idx;
    logic             start;
    logic             xfer;
    logic             wr_en;
    logic [DATA_W-1:0] rd_word;

    mbt_decode #(
        .ADDR_W   (DATA_W),
        .IDX_W    (IDX_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr (ad_i),
        .cmd  (cmd_be_n),
        .hit  (dec_hit),
        .is_wr(dec_wr),
        .idx  (dec_idx)
    );

    mbt_regs #(
        .WORDS (WIN_WORDS),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wr_idx(r_q.idx),
        .wdata (ad_i),
        .be_n  (cmd_be_n),
        .rd_idx(r_q.idx),
        .rdata (rd_word)
    );

    always_comb begin
        start = (r_q.st == ST_IDLE) && !txn_req_n && r_q.req_prev;
        xfer  = (r_q.st != ST_IDLE) && !init_rdy_n;
        wr_en = xfer && (r_q.st == ST_WR);

        r_d          = r_q;
        r_d.req_prev = txn_req_n;
        if (start && dec_hit) begin
            r_d.st  = dec_wr ? ST_WR : ST_RD;
            r_d.idx = dec_idx;
        end else if (xfer) begin
            r_d.idx = r_q.idx + 1'b1;
            if (txn_req_n) begin
                r_d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign claim_n   = (r_q.st == ST_IDLE);
    assign tgt_rdy_n = (r_q.st == ST_IDLE);
    assign ad_oe     = (r_q.st == ST_RD);
    assign ad_o      = ad_oe ? rd_word : '0;

    AST_MISS_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dec_hit) |=> claim_n); // R3

    AST_NO_MIDBURST_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_n && !r_q.req_prev) |=> claim_n); // R9

    AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_n && !init_rdy_n && txn_req_n) |=> (claim_n && tgt_rdy_n && !ad_oe)); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_n && !init_rdy_n && !txn_req_n) |=> (r_q.idx == IDX_W'($past(r_q.idx) + 1'b1))); // R7

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_n && init_rdy_n) |=> (!claim_n && $stable(r_q.idx))); // R6

endmodule

// File: tb/test_mux_bus_target.sv
module test_mux_bus_target;

    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_req_n = 1'b1;
    logic [31:0] ad_i = '0;
    logic [31:0] ad_o;
    logic        ad_oe;
    logic [3:0]  cmd_be_n = 4'hF;
    logic        init_rdy_n = 1'b1;
    logic        tgt_rdy_n;
    logic        claim_n;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] model [16];
    logic [31:0] wd  [32];
    logic [3:0]  wbe [32];

    always #4 clk = ~clk;

    mux_bus_target #(.BASE_ADDR(BASE), .WIN_WORDS(16)) i_mux_bus_target (
        .clk(clk), .rst_n(rst_n), .txn_req_n(txn_req_n), .ad_i(ad_i),
        .ad_o(ad_o), .ad_oe(ad_oe), .cmd_be_n(cmd_be_n),
        .init_rdy_n(init_rdy_n), .tgt_rdy_n(tgt_rdy_n), .claim_n(claim_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One transaction of n data phases; wait_at inserts a one-cycle initiator stall.
    task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                           input bit claim_exp, input int wait_at, input string rtag);
        bit       is_wr = (cmd == 4'b0111);
        int       idx = int'(addr[5:2]);
        @(negedge clk);
        txn_req_n = 1'b0; ad_i = addr; cmd_be_n = cmd; init_rdy_n = 1'b1;
        @(negedge clk);
        chk(claim_exp ? "R2 claim" : "R3 no claim", 32'(claim_n), 32'(!claim_exp));
        if (claim_exp) chk("R2 target ready", 32'(tgt_rdy_n), 32'd0);
        if (claim_exp && !is_wr) chk("R5 drive enable", 32'(ad_oe), 32'd1);
        for (int i = 0; i < n; i++) begin
            if (i == wait_at) begin
                init_rdy_n = 1'b1; ad_i = 32'hDEAD_BEEF; cmd_be_n = 4'h0;
                @(negedge clk);
                chk("R6 claim held in wait", 32'(claim_n), 32'(!claim_exp));
                if (claim_exp && !is_wr) chk("R6 read word held", ad_o, model[idx]);
            end
            ad_i = is_wr ? wd[i] : (claim_exp ? 32'h0 : wd[i]);
            cmd_be_n = wbe[i];
            init_rdy_n = 1'b0;
            txn_req_n = (i == n - 1);
            if (claim_exp && !is_wr) chk(rtag, ad_o, model[idx]);
            if (!claim_exp) chk("R9 no claim in data phase", 32'(claim_n), 32'd1);
            @(negedge clk);
            if (claim_exp && is_wr) begin
                for (int b = 0; b < 4; b++)
                    if (!wbe[i][b]) model[idx][b*8 +: 8] = wd[i][b*8 +: 8];
            end
            idx = (idx + 1) % 16;
        end
        txn_req_n = 1'b1; init_rdy_n = 1'b1; cmd_be_n = 4'hF; ad_i = '0;
        chk("R8 claim released", 32'(claim_n), 32'd1);
        chk("R8 target ready released", 32'(tgt_rdy_n), 32'd1);
        chk("R8 drive released", 32'(ad_oe), 32'd0);
    endtask

    task automatic read_words(input int first, input int n, input string rtag);
        run_txn(4'b0110, BASE + 32'(first * 4), n, 1'b1, -1, rtag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hang, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        for (int i = 0; i < 32; i++) begin wd[i] = '0; wbe[i] = 4'h0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 claim idle", 32'(claim_n), 32'd1);
        chk("R1 ready idle", 32'(tgt_rdy_n), 32'd1);
        chk("R1 drive idle", 32'(ad_oe), 32'd0);
        rst_n = 1'b1;
        read_words(0, 16, "R1 zero after reset");

        // R4/R2: full-word write burst over the whole window
        for (int i = 0; i < 16; i++) begin
            wd[i] = (32'h0101_0101 * 32'(i + 1)) ^ {4'(i), 28'h0};
            wbe[i] = 4'h0;
        end
        run_txn(4'b0111, BASE, 16, 1'b1, -1, "R4");
        read_words(0, 16, "R5 read burst");
        // R7: burst starting mid-window wraps past word 15
        read_words(10, 12, "R7 wrap read");
        for (int i = 0; i < 6; i++) wd[i] = 32'hC0DE_0000 + 32'(i);
        run_txn(4'b0111, BASE + 32'd56, 6, 1'b1, -1, "R7");
        read_words(0, 16, "R7 wrap write readback");

        // R4: all sixteen byte-enable patterns on word 5
        for (int be = 0; be < 16; be++) begin
            wd[0] = {4{4'(be), 4'hA}} ^ 32'h1234_5678;
            wbe[0] = 4'(be);
            run_txn(4'b0111, BASE + 32'd20, 1, 1'b1, -1, "R4");
            read_words(5, 1, "R4 byte lanes");
        end
        wbe[0] = 4'h0;

        // R3: every other command code is ignored
        for (int c = 0; c < 16; c++) begin
            if (c == 6 || c == 7) continue;
            wd[0] = 32'hFFFF_FFFF; wbe[0] = 4'h0;
            run_txn(4'(c), BASE + 32'd8, 1, 1'b0, -1, "R3");
            read_words(2, 1, "R3 no write on other command");
        end
        // R3: addresses outside the window or misaligned
        run_txn(4'b0111, BASE + 32'd64, 1, 1'b0, -1, "R3");
        run_txn(4'b0111, BASE - 32'd4, 1, 1'b0, -1, "R3");
        run_txn(4'b0111, 32'h8000_1000, 1, 1'b0, -1, "R3");
        run_txn(4'b0111, BASE + 32'd1, 1, 1'b0, -1, "R3");
        read_words(0, 16, "R3 window unchanged");

        // R6: wait states inside write and read bursts
        for (int i = 0; i < 4; i++) begin wd[i] = 32'hA5A5_0000 | 32'(i); wbe[i] = 4'h0; end
        run_txn(4'b0111, BASE + 32'd12, 4, 1'b1, 1, "R6");
        run_txn(4'b0110, BASE + 32'd12, 4, 1'b1, 2, "R6 read with wait");
        read_words(0, 16, "R6 window after stalled write");

        // R9: unclaimed transaction whose data phases mimic a claimable write
        for (int i = 0; i < 3; i++) begin wd[i] = BASE; wbe[i] = 4'b0111; end
        run_txn(4'b0010, 32'h0000_2000, 3, 1'b0, -1, "R9");
        read_words(0, 16, "R9 window unchanged");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule